// File: doc/BRIEF.md
# One-Wire Bus Slot Engine

This block is the timing engine of a single-pin 1-Wire bus master. It generates the bus reset pulse and decides whether a device answered with a presence pulse. It also cuts each bit into a fixed-length time slot. All timing is counted in 6 µs ticks. A divider of `CLK_MHZ * 6` system clocks produces each tick. The divider restarts whenever a new operation begins, so every waveform is aligned to the clock edge that accepted the request.

The pin is open drain. The block pulls the line low only by raising `line_oe`, and `line_out` is tied to 0. A byte is sent least significant bit first, and every slot samples the line. Each byte written therefore also returns a byte read. To read from a device, the host writes 0xFF and takes the returned byte. The engine takes one job at a time, and `busy` is high while a job runs. Reset and byte requests that arrive while busy is high are dropped, not queued.

Top module: `ow_slot_engine`

## Requirements
- R1: After `rst_n` is released the engine is idle: `busy` low, `line_oe` low, `tx_ready` high, `rx_valid` and `presence_valid` low. Whenever the engine is idle, `line_oe` is low.
- R2: `line_out` is 0 at all times. The line is pulled low only through `line_oe`.
- R3: An accepted reset first leaves the line released for 10 ticks, then drives it low for 80 ticks, then spends 80 ticks on presence detection. After these 170 ticks, `presence_valid` pulses for one cycle and `busy` falls in the same cycle.
- R4: Presence is 1 if the line reads low at any of 32 sample points and 0 otherwise. The first sample point is 4 ticks after release, and the points are 2 ticks apart, so the last is 66 ticks after release. A low pulse that ends before the first point or starts after the last point gives 0.
- R5: Every bit slot lasts 15 ticks, and the line falls 3 ticks into the slot. For a 1 bit the line is low for 2 ticks. For a 0 bit it is low for 12 ticks.
- R6: Bits leave `tx_byte` least significant bit first. Bit 0 of `tx_byte` goes in the first slot.
- R7: The line is sampled 3 ticks after each falling edge. The captured bit is the sample ANDed with the transmitted bit. After 8 slots (120 ticks), `rx_byte` holds the captured bits, with the first slot in bit 0, and `rx_valid` pulses for one cycle.
- R8: Writing 0xFF returns the byte that a device places on the line by holding it low in the slots for its 0 bits.
- R9: A reset or byte request made while `busy` is high has no effect. The job in progress runs to its normal end, and no further job follows it.
- R10: `tx_ready` is high only when the engine is idle and `reset_req` is low. When both requests arrive together, the reset is taken.
- R11: One tick lasts `CLK_MHZ * 6` clock cycles. With `CLK_MHZ = 1`, the first falling edge of a byte is seen 19 cycles after the request is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reset_req | input | 1 | Start a bus reset and presence check (taken when idle) |
| presence_valid | output | 1 | One-cycle pulse when the presence result is ready |
| presence | output | 1 | 1 when at least one device answered the last reset |
| tx_valid | input | 1 | Byte request valid |
| tx_ready | output | 1 | Engine can accept a byte request |
| tx_byte | input | 8 | Byte to transmit, LSB first |
| rx_valid | output | 1 | One-cycle pulse when the received byte is ready |
| rx_byte | output | 8 | Bits captured during the last byte |
| busy | output | 1 | A reset or byte job is running |
| line_in | input | 1 | Sensed bus level |
| line_oe | output | 1 | 1 pulls the bus low |
| line_out | output | 1 | Output data level, constant 0 |

## Verification
The hardest case to reach is the edge of the presence window. A device pulse only counts if it covers one of the 32 sample points, so pulses that just miss the first or last point must be told apart from pulses that just cover it. The bench's device model measures time from the release edge it observes. It then places short low pulses just before, across, and just after the first and last sample points. A second hard case is a request made in the middle of a job. The bench raises both requests about 200 cycles into a byte and into a reset, then checks that the job ends at its normal time and that no extra result pulse appears.

// File: rtl/ow_pkg.sv
// Package: shared state type and tick-count constants for the 1-Wire slot engine.
// Assumes every timing value is an exact multiple of the 6 us tick.
package ow_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RESET = 2'd1,
        ST_SLOT  = 2'd2
    } ow_state_e;

    localparam int TICK_US       = 6;

    // Reset sequence, in ticks
    localparam int RST_GAP_TK    = 60  / TICK_US;
    localparam int RST_LOW_TK    = 480 / TICK_US;
    localparam int PRES_WAIT_TK  = 24  / TICK_US;
    localparam int PRES_STEP_TK  = 12  / TICK_US;
    localparam int PRES_SAMPLES  = 32;
    localparam int PRES_TAIL_TK  = 72  / TICK_US;
    localparam int RST_TOTAL_TK  = RST_GAP_TK + RST_LOW_TK + PRES_WAIT_TK
                                 + PRES_SAMPLES * PRES_STEP_TK + PRES_TAIL_TK;
    localparam int RST_LOW_END   = RST_GAP_TK + RST_LOW_TK;
    localparam int POLL_FIRST    = RST_LOW_END + PRES_WAIT_TK - 1;
    localparam int POLL_LAST     = POLL_FIRST + (PRES_SAMPLES - 1) * PRES_STEP_TK;

    // Bit slot, in ticks
    localparam int SLOT_LEAD_TK  = 18 / TICK_US;
    localparam int SLOT_LOW_TK   = 12 / TICK_US;
    localparam int SLOT_SET_TK   = 6  / TICK_US;
    localparam int SLOT_TOTAL_TK = 90 / TICK_US;
    localparam int SLOT_SAMP_IDX = SLOT_LEAD_TK + SLOT_LOW_TK + SLOT_SET_TK - 1;

endpackage

// File: rtl/ow_tick_gen.sv
// Module: ow_tick_gen
// Produces a one-cycle tick every DIV clocks. The count restarts on sync, so the
// first tick after a start lands exactly DIV cycles later.
// Assumes DIV >= 1.
module ow_tick_gen #(
    parameter int DIV = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Divider counter, cleared on reset and on each job start
    always_ff @(posedge clk) begin
        if (!rst_n || sync) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == LAST);

endmodule

// File: rtl/ow_byte_shift.sv
// Module: ow_byte_shift
// One register serves both directions. It loads the byte to send, presents its
// LSB as the current bit, and on each shift brings the captured bit in at the MSB.
// After W shifts it holds the received byte with the first bit in bit 0.
module ow_byte_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         shift,
    input  logic         shift_in,
    output logic         cur_bit,
    output logic [W-1:0] data
);
    logic [W-1:0] sh;

    // Load or shift the combined transmit/receive register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (load) begin
            sh <= load_data;
        end else if (shift) begin
            sh <= {shift_in, sh[W-1:1]};
        end
    end

    assign cur_bit = sh[0];
    assign data    = sh;

endmodule

// File: rtl/ow_presence.sv
// Module: ow_presence
// Records whether any presence sample saw the line low. It is cleared when a
// reset job starts.
module ow_presence (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sample,
    input  logic line_in,
    output logic found
);
    // Sticky low-detect flag
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            found <= 1'b0;
        end else if (sample && !line_in) begin
            found <= 1'b1;
        end
    end

endmodule

// File: rtl/ow_seq.sv
// Module: ow_seq
// Job sequencer. It runs either the reset and presence sequence or BITS bit
// slots, counting ticks within the job. It drives the line enable and the
// sample and shift strobes. It accepts a request only when idle.
module ow_seq
    import ow_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic reset_req,
    input  logic tx_valid,
    input  logic line_in,
    input  logic cur_bit,
    input  logic pres_found,
    output logic tx_ready,
    output logic busy,
    output logic line_oe,
    output logic div_sync,
    output logic load,
    output logic shift,
    output logic shift_in,
    output logic pres_clear,
    output logic pres_sample,
    output logic presence_valid,
    output logic presence,
    output logic rx_valid
);
    localparam int TCW = $clog2(RST_TOTAL_TK);
    localparam int BW  = (BITS > 1) ? $clog2(BITS) : 1;

    localparam logic [TCW-1:0] T_RST_LAST  = TCW'(RST_TOTAL_TK - 1);
    localparam logic [TCW-1:0] T_LOW_BEG   = TCW'(RST_GAP_TK);
    localparam logic [TCW-1:0] T_LOW_END   = TCW'(RST_LOW_END);
    localparam logic [TCW-1:0] T_P_FIRST   = TCW'(POLL_FIRST);
    localparam logic [TCW-1:0] T_P_LAST    = TCW'(POLL_LAST);
    localparam logic [TCW-1:0] T_P_STEP    = TCW'(PRES_STEP_TK);
    localparam logic [TCW-1:0] T_S_FALL    = TCW'(SLOT_LEAD_TK);
    localparam logic [TCW-1:0] T_S_RISE1   = TCW'(SLOT_LEAD_TK + SLOT_LOW_TK);
    localparam logic [TCW-1:0] T_S_SAMP    = TCW'(SLOT_SAMP_IDX);
    localparam logic [TCW-1:0] T_S_LAST    = TCW'(SLOT_TOTAL_TK - 1);
    localparam logic [BW-1:0]  B_LAST      = BW'(BITS - 1);

    ow_state_e      state;
    logic [TCW-1:0] tcnt;
    logic [BW-1:0]  bit_idx;
    logic           samp_q;
    logic [TCW-1:0] poll_off;

    logic idle, start_rst, start_byte, rst_end, slot_end, slot_samp, in_poll;

    // Request decode and strobes derived from the tick position
    always_comb begin
        idle       = (state == ST_IDLE);
        start_rst  = idle && reset_req;
        start_byte = idle && !reset_req && tx_valid;
        rst_end    = (state == ST_RESET) && tick && (tcnt == T_RST_LAST);
        slot_end   = (state == ST_SLOT) && tick && (tcnt == T_S_LAST);
        slot_samp  = (state == ST_SLOT) && tick && (tcnt == T_S_SAMP);
        poll_off   = tcnt - T_P_FIRST;
        in_poll    = (tcnt >= T_P_FIRST) && (tcnt <= T_P_LAST);
    end

    assign tx_ready    = idle && !reset_req;
    assign busy        = !idle;
    assign div_sync    = start_rst || start_byte;
    assign load        = start_byte;
    assign pres_clear  = start_rst;
    assign pres_sample = (state == ST_RESET) && tick && in_poll
                         && ((poll_off % T_P_STEP) == '0);
    assign shift       = slot_end;
    assign shift_in    = samp_q;

    // Open-drain enable: reset low phase, or the low part of a slot
    always_comb begin
        line_oe = 1'b0;
        if (state == ST_RESET) begin
            line_oe = (tcnt >= T_LOW_BEG) && (tcnt < T_LOW_END);
        end else if (state == ST_SLOT) begin
            line_oe = (tcnt >= T_S_FALL) && ((tcnt < T_S_RISE1) || !cur_bit);
        end
    end

    // Job state, tick counter and bit index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            tcnt    <= '0;
            bit_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    tcnt    <= '0;
                    bit_idx <= '0;
                    if (start_rst) begin
                        state <= ST_RESET;
                    end else if (start_byte) begin
                        state <= ST_SLOT;
                    end
                end
                ST_RESET: begin
                    if (tick) begin
                        if (tcnt == T_RST_LAST) begin
                            state <= ST_IDLE;
                            tcnt  <= '0;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                ST_SLOT: begin
                    if (tick) begin
                        if (tcnt == T_S_LAST) begin
                            tcnt <= '0;
                            if (bit_idx == B_LAST) begin
                                state <= ST_IDLE;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Slot sample: a 0 bit always captures 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= 1'b0;
        end else if (slot_samp) begin
            samp_q <= line_in & cur_bit;
        end
    end

    // Completion pulses and the latched presence result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presence_valid <= 1'b0;
            presence       <= 1'b0;
            rx_valid       <= 1'b0;
        end else begin
            presence_valid <= rst_end;
            rx_valid       <= slot_end && (bit_idx == B_LAST);
            if (rst_end) begin
                presence <= pres_found;
            end
        end
    end

endmodule

// File: rtl/ow_slot_engine.sv
// Module: ow_slot_engine (top)
// Single-pin 1-Wire master timing engine: reset and presence detection, and
// LSB-first byte transfer in fixed 90 us slots.
// Assumes line_in is already synchronised to clk and that CLK_MHZ * 6 clocks
// make one 6 us tick.
module ow_slot_engine #(
    parameter int CLK_MHZ = 50,
    parameter int BYTE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_req,
    output logic              presence_valid,
    output logic              presence,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              busy,
    input  logic              line_in,
    output logic              line_oe,
    output logic              line_out
);
    localparam int DIV = CLK_MHZ * ow_pkg::TICK_US;

    logic tick, div_sync, load, shift, shift_in, cur_bit;
    logic pres_clear, pres_sample, pres_found;

    ow_tick_gen #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .sync  (div_sync),
        .tick  (tick)
    );

    ow_byte_shift #(.W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (tx_byte),
        .shift     (shift),
        .shift_in  (shift_in),
        .cur_bit   (cur_bit),
        .data      (rx_byte)
    );

    ow_presence u_pres (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (pres_clear),
        .sample  (pres_sample),
        .line_in (line_in),
        .found   (pres_found)
    );

    ow_seq #(.BITS(BYTE_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick           (tick),
        .reset_req      (reset_req),
        .tx_valid       (tx_valid),
        .line_in        (line_in),
        .cur_bit        (cur_bit),
        .pres_found     (pres_found),
        .tx_ready       (tx_ready),
        .busy           (busy),
        .line_oe        (line_oe),
        .div_sync       (div_sync),
        .load           (load),
        .shift          (shift),
        .shift_in       (shift_in),
        .pres_clear     (pres_clear),
        .pres_sample    (pres_sample),
        .presence_valid (presence_valid),
        .presence       (presence),
        .rx_valid       (rx_valid)
    );

    // Open drain: the data level never leaves 0
    assign line_out = 1'b0;

endmodule

// File: rtl/ow_slot_engine_chk.sv
// Module: ow_slot_engine_chk
// Port-level properties of the slot engine, bound to every instance of the top.
module ow_slot_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic reset_req,
    input logic tx_valid,
    input logic tx_ready,
    input logic busy,
    input logic line_oe,
    input logic line_out,
    input logic rx_valid,
    input logic presence_valid
);
    p_line_low_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_out == 1'b0);

    p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !line_oe);

    p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (!busy && !reset_req));

    p_byte_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> busy);

    p_reset_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req && !busy) |=> busy);

    p_pres_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        presence_valid |-> (!busy && $past(busy)));

    p_rx_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (!busy && $past(busy)));

    p_one_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_valid, presence_valid}));

endmodule

bind ow_slot_engine ow_slot_engine_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reset_req      (reset_req),
    .tx_valid       (tx_valid),
    .tx_ready       (tx_ready),
    .busy           (busy),
    .line_oe        (line_oe),
    .line_out       (line_out),
    .rx_valid       (rx_valid),
    .presence_valid (presence_valid)
);

// File: tb/ow_slot_engine_test.sv
module ow_slot_engine_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reset_req = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       presence_valid, presence, tx_ready, rx_valid, busy;
    logic       line_oe, line_out, line_in;
    logic [7:0] rx_byte;
    logic       slave_pull = 1'b0;

    int n_vec = 0;
    int n_bad = 0;

    // Bus model: open-drain wired AND of master and device
    assign line_in = ~(line_oe | slave_pull);

    always #10 clk = ~clk;

    ow_slot_engine #(.CLK_MHZ(1), .BYTE_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .reset_req(reset_req),
        .presence_valid(presence_valid), .presence(presence),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .busy(busy),
        .line_in(line_in), .line_oe(line_oe), .line_out(line_out)
    );

    // Monitor and device-model state
    int cyc = 0;
    int np = 0;
    int pw [16];
    int rise_cyc [16];
    int hi = 0;
    logic oe_q = 1'b0;
    int pv_cnt = 0;
    int rv_cnt = 0;
    int mode = 0;          // 0 silent, 1 presence pulse, 2 data bits
    int ps = 0, pl = 0;
    int rel = 0;
    logic armed = 1'b0;
    logic [7:0] sbyte = 8'hFF;
    int sbit = 0;
    int fall = 100;
    logic hold = 1'b0;

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (presence_valid) pv_cnt++;
            if (rx_valid) rv_cnt++;
            if (line_oe && !oe_q) begin
                if (np < 16) rise_cyc[np] = cyc;
                hi = 1;
                fall = 0;
                if (mode == 2) begin
                    hold = !sbyte[sbit % 8];
                    sbit++;
                end
            end else begin
                if (line_oe) hi++;
                fall++;
            end
            if (!line_oe && oe_q) begin
                if (np < 16) pw[np] = hi;
                np++;
                if (hi >= 400) begin
                    armed = 1'b1;
                    rel = 0;
                end
            end else begin
                rel++;
            end
            oe_q = line_oe;
            if (mode == 1)
                slave_pull = armed && (rel >= ps) && (rel < ps + pl);
            else if (mode == 2)
                slave_pull = hold && (fall < 30);
            else
                slave_pull = 1'b0;
            if (armed && rel > 600) armed = 1'b0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi_v);
        n_vec++;
        if (act < lo || act > hi_v) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi_v);
        end
    endtask

    // Run one reset; returns presence and the cycles until presence_valid
    task automatic run_reset(output logic pres, output int dur);
        int n = 0;
        np = 0;
        @(negedge clk);
        reset_req = 1'b1;
        @(negedge clk);
        reset_req = 1'b0;
        n = 1;
        while (!presence_valid && n < 3000) begin
            @(negedge clk);
            n++;
        end
        pres = presence;
        dur = n;
    endtask

    task automatic t_reset_state;
        chk("R1 busy", busy, 0);
        chk("R1 line_oe", line_oe, 0);
        chk("R1 tx_ready", tx_ready, 1);
        chk("R1 valids", {rx_valid, presence_valid}, 0);
        chk("R2 line_out", line_out, 0);
    endtask

    task automatic t_presence(input string tag, input int m, input int s, input int l, input int exp);
        logic p;
        int d;
        mode = m; ps = s; pl = l;
        run_reset(p, d);
        chk(tag, p, exp);
        mode = 0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset_timing;
        logic p;
        int d;
        int pv0;
        mode = 0;
        pv0 = pv_cnt;
        run_reset(p, d);
        chk_rng("R3 reset duration", d, 1019, 1023);
        chk("R3 one low pulse", np, 1);
        chk("R3 low width 80 ticks", pw[0], 480);
        chk("R3 presence_valid once", pv_cnt - pv0, 1);
        chk("R3 busy after", busy, 0);
        chk("R4 silent bus gives 0", p, 0);
        repeat (5) @(negedge clk);
    endtask

    // Send one byte; checks result, slot waveform and duration
    task automatic t_byte(input string tag, input logic [7:0] tb, input int m,
                          input logic [7:0] sb, input logic [7:0] exp_rx);
        int n = 0;
        int bad = 0;
        int t0;
        mode = m; sbyte = sb; sbit = 0;
        np = 0;
        @(negedge clk);
        chk("R10 ready when idle", tx_ready, 1);
        tx_byte = tb;
        tx_valid = 1'b1;
        t0 = cyc;
        @(negedge clk);
        tx_valid = 1'b0;
        n = 1;
        while (!rx_valid && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " R7 rx_byte"}, rx_byte, exp_rx);
        chk_rng("R7 byte duration", n, 719, 723);
        chk("R5 eight slots", np, 8);
        for (int i = 0; i < 8; i++) begin
            if (pw[i] != (tb[i] ? 12 : 72)) bad++;
            if (rise_cyc[i] - t0 != 19 + 90 * i) bad++;
        end
        chk({tag, " R5 R6 slot widths and LSB-first order"}, bad, 0);
        chk("R11 first fall offset", rise_cyc[0] - t0, 19);
        mode = 0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_busy_ignore;
        int pv0, rv0;
        int n;
        logic p;
        int d;
        pv0 = pv_cnt; rv0 = rv_cnt;
        mode = 0;
        @(negedge clk);
        tx_byte = 8'h5A;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (200) @(negedge clk);
        reset_req = 1'b1;
        tx_valid = 1'b1;
        tx_byte = 8'h00;
        chk("R10 ready low while busy", tx_ready, 0);
        @(negedge clk);
        reset_req = 1'b0;
        tx_valid = 1'b0;
        n = 0;
        while (!rx_valid && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk("R9 byte unchanged", rx_byte, 8'h5A);
        chk_rng("R9 byte ends on time", n, 516, 522);
        repeat (20) @(negedge clk);
        chk("R9 no presence result", pv_cnt - pv0, 0);
        chk("R9 no queued job", busy, 0);
        // byte request during a reset
        rv0 = rv_cnt;
        fork
            run_reset(p, d);
            begin
                repeat (200) @(negedge clk);
                tx_valid = 1'b1;
                @(negedge clk);
                tx_valid = 1'b0;
            end
        join
        chk_rng("R9 reset ends on time", d, 1019, 1023);
        repeat (20) @(negedge clk);
        chk("R9 no byte after reset", rv_cnt - rv0, 0);
        chk("R9 idle after reset", busy, 0);
    endtask

    task automatic t_priority;
        int rv0, pv0, n;
        rv0 = rv_cnt; pv0 = pv_cnt;
        @(negedge clk);
        reset_req = 1'b1;
        tx_valid = 1'b1;
        tx_byte = 8'h11;
        #1;
        chk("R10 ready low with reset_req", tx_ready, 0);
        @(negedge clk);
        reset_req = 1'b0;
        tx_valid = 1'b0;
        n = 0;
        while (!presence_valid && n < 3000) begin
            @(negedge clk);
            n++;
        end
        repeat (20) @(negedge clk);
        chk("R10 reset taken", pv_cnt - pv0, 1);
        chk("R10 byte not taken", rv_cnt - rv0, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_reset_timing();
        t_presence("R4 pulse mid window", 1, 60, 120, 1);
        t_presence("R4 pulse ends before first sample", 1, 2, 18, 0);
        t_presence("R4 pulse covers first sample", 1, 20, 6, 1);
        t_presence("R4 pulse covers last sample", 1, 390, 10, 1);
        t_presence("R4 pulse after last sample", 1, 405, 65, 0);
        t_byte("write 01", 8'h01, 0, 8'hFF, 8'h01);
        t_byte("write A5", 8'hA5, 0, 8'hFF, 8'hA5);
        t_byte("R8 read 3C", 8'hFF, 2, 8'h3C, 8'h3C);
        t_byte("R8 read C1", 8'hFF, 2, 8'hC1, 8'hC1);
        t_byte("R7 zero bits mask", 8'hF0, 2, 8'h0F, 8'h00);
        t_busy_ignore();
        t_priority();
        chk("R2 line_out end", line_out, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule